// File: doc/BRIEF.md
# Bidirectional GPIO Port with Bus-Mode Override

This block is an 8-bit general purpose I/O port. A data register and a direction register sit on a simple peripheral register bus. In normal operation the port drives its pins from the data register, and the direction bits set the per-pin output enables. The pin inputs pass through a two-flop synchronizer. A read of the data register returns either the stored bit or the synchronized pin, chosen separately for each bit by its direction bit.

A 2-bit mode input changes how the port is used. In expanded mode the pins stop acting as GPIO and carry an external data bus instead. The pin data and output enable then come from an external bus interface, and the synchronized pin values go back to that interface.

Emulation mode keeps the pins on the external bus. In addition, every access to the data register is forwarded to an external bus port through a request/acknowledge handshake. A forwarded read returns the external data. A forwarded write also updates the local register. Direction register accesses stay local in every mode.

Top module: `gpio_bidir_port`

## Requirements
- R1: After synchronous reset, the data register and the direction register both read 0x00, and in mode 00 every `pin_oe` bit is 0.
- R2: A write to offset 0x06 stores `bus_wdata` in the direction register, and a read of offset 0x06 returns it, in every mode.
- R3: A read of offset 0x05 outside emulation returns, for each bit, the data register bit when its direction bit is 1 and the synchronized pin bit when it is 0. A write to offset 0x05 outside emulation stores `bus_wdata` in the data register.
- R4: `xbus_din` and the pin value seen by reads equal `pin_in` delayed by exactly two clock edges.
- R5: In mode 00, `pin_oe` equals the direction register and `pin_out` equals the data register.
- R6: In modes 01, 10 and 11, `pin_out` equals `xbus_dout` bit for bit, and every `pin_oe` bit equals `xbus_oe`. A register write in these modes does not change the pins.
- R7: In mode 10, a data register read raises `ext_req` for exactly one cycle, in the cycle after the access starts, with `ext_wr`=0 and `ext_addr`=0x05. `bus_ready` stays low until the first cycle after that in which `ext_ack` is high. In that cycle `bus_ready` is high and `bus_rdata` equals `ext_rdata`.
- R8: In emulation, a data register write is forwarded the same way, with `ext_wr`=1 and `ext_wdata` equal to `bus_wdata`. At completion it also writes `bus_wdata` into the local data register.
- R9: A read of any offset other than 0x05 or 0x06 returns 0x00. A write to such an offset changes neither register.
- R10: Every access that is not forwarded completes in its first cycle, with `bus_ready` equal to `bus_sel`.
- R11: Mode 11 behaves exactly like mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 normal, 01 expanded, 10/11 emulation |
| bus_sel | input | 1 | Register access active, held until bus_ready |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_ready | output | 1 | Access completes this cycle |
| pin_in | input | DATA_W | Pad input values |
| pin_out | output | DATA_W | Pad output values |
| pin_oe | output | DATA_W | Pad output enables |
| xbus_dout | input | DATA_W | External bus data to drive on pins |
| xbus_oe | input | 1 | External bus drive enable |
| xbus_din | output | DATA_W | Synchronized pin values to external bus |
| ext_req | output | 1 | One-cycle forwarded access request |
| ext_wr | output | 1 | Forwarded access is a write |
| ext_addr | output | ADDR_W | Forwarded offset |
| ext_wdata | output | DATA_W | Forwarded write data |
| ext_rdata | input | DATA_W | External read data |
| ext_ack | input | 1 | External access done |

## Verification
The bench builds the port with its default values: 8 data bits, an 8-bit offset and two synchronizer stages. With the 8-bit offset, an unmapped offset right next to the two registers can be reached. With two stages, the exact two-edge pin latency becomes a fixed cycle count that the bench can check. The bench steps through all four mode codes and forwarded accesses with acknowledge delays of zero and several cycles.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_EMUL     = 2'b10,
        MODE_EMUL_ALT = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        FWD_IDLE = 2'b00,
        FWD_REQ  = 2'b01,
        FWD_WAIT = 2'b10
    } fwd_state_e;

    typedef struct packed {
        logic data_hit;
        logic dir_hit;
        logic unmapped;
    } reg_hit_t;

    localparam int unsigned DATA_OFFSET = 5;
    localparam int unsigned DIR_OFFSET  = 6;

    function automatic logic mode_is_emul(port_mode_e m);
        return (m == MODE_EMUL) || (m == MODE_EMUL_ALT);
    endfunction

    function automatic logic mode_is_extbus(port_mode_e m);
        return m != MODE_SINGLE;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    // R4: the first stage always holds the input seen at the previous edge
    p_first_stage_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> stage_q[0] == $past(din));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] gpio_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_dir)  dir_q  <= wdata;
        end
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_rd_bit
            assign gpio_rd[b] = dir_q[b] ? data_q[b] : pin_sync[b];
        end
    endgenerate

    // R2 / R9: registers only change on their own write strobe
    p_dir_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));
    p_data_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(data_q));

endmodule

// File: rtl/gpio_emu_fwd.sv
module gpio_emu_fwd
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [W-1:0]      acc_wdata,
    input  logic              ext_ack,
    output logic              busy,
    output logic              done,
    output logic              ext_req,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [W-1:0]      ext_wdata
);

    fwd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            FWD_IDLE: if (start) state_d = FWD_REQ;
            FWD_REQ:  state_d = FWD_WAIT;
            FWD_WAIT: if (ext_ack) state_d = FWD_IDLE;
            default:  state_d = FWD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FWD_IDLE;
            ext_wr    <= 1'b0;
            ext_addr  <= '0;
            ext_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FWD_IDLE && start) begin
                ext_wr    <= acc_wr;
                ext_addr  <= acc_addr;
                ext_wdata <= acc_wdata;
            end
        end
    end

    assign busy    = state_q != FWD_IDLE;
    assign ext_req = state_q == FWD_REQ;
    assign done    = (state_q == FWD_WAIT) && ext_ack;

    // R7: request is a single-cycle pulse that follows the start
    p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ext_req |=> !ext_req);
    p_req_after_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> ext_req);
    p_no_done_on_req_r7: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> !done);

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  port_mode_e   mode,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] xbus_dout,
    input  logic         xbus_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    always_comb begin
        if (mode_is_extbus(mode)) begin
            pin_out = xbus_dout;
            pin_oe  = {W{xbus_oe}};
        end else begin
            pin_out = data_q;
            pin_oe  = dir_q;
        end
    end

    // R6: external bus drives all pins together
    p_ext_oe_uniform_r6: assert property (@(posedge clk) disable iff (rst)
        mode_is_extbus(mode) |-> (pin_oe == '0 || pin_oe == '1));

endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
    import gpio_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    input  logic [DATA_W-1:0] xbus_dout,
    input  logic              xbus_oe,
    output logic [DATA_W-1:0] xbus_din,
    output logic              ext_req,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ack
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFFSET);
    localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(DIR_OFFSET);

    port_mode_e        mode_e;
    reg_hit_t          hit;
    logic              fwd_needed, fwd_busy, fwd_done, fwd_start;
    logic              wr_data, wr_dir;
    logic [DATA_W-1:0] pin_sync, data_q, dir_q, gpio_rd;

    assign mode_e = port_mode_e'(mode);

    always_comb begin
        hit.data_hit = bus_addr == DATA_ADDR;
        hit.dir_hit  = bus_addr == DIR_ADDR;
        hit.unmapped = !(hit.data_hit || hit.dir_hit);
    end

    assign fwd_needed = bus_sel && hit.data_hit && mode_is_emul(mode_e);
    assign fwd_start  = fwd_needed && !fwd_busy;

    assign bus_ready = fwd_needed ? fwd_done : bus_sel;

    assign wr_data = (bus_sel && bus_wr && hit.data_hit && !fwd_needed)
                   || (fwd_done && bus_wr);
    assign wr_dir  = bus_sel && bus_wr && hit.dir_hit;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (fwd_needed)        bus_rdata = ext_rdata;
            else if (hit.data_hit) bus_rdata = gpio_rd;
            else if (hit.dir_hit)  bus_rdata = dir_q;
        end
    end

    assign xbus_din = pin_sync;

    gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio_regfile #(.W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .wr_dir   (wr_dir),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .gpio_rd  (gpio_rd)
    );

    gpio_emu_fwd #(.W(DATA_W), .ADDR_W(ADDR_W)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .start     (fwd_start),
        .acc_wr    (bus_wr),
        .acc_addr  (bus_addr),
        .acc_wdata (bus_wdata),
        .ext_ack   (ext_ack),
        .busy      (fwd_busy),
        .done      (fwd_done),
        .ext_req   (ext_req),
        .ext_wr    (ext_wr),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata)
    );

    gpio_pin_mux #(.W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .xbus_dout (xbus_dout),
        .xbus_oe   (xbus_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R1: pins come out of reset as inputs
    p_reset_inputs_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && mode_e == MODE_SINGLE) |-> pin_oe == '0);
    // R10: non-forwarded accesses finish at once
    p_local_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !mode_is_emul(mode_e)) |-> bus_ready);
    // R2: a completed direction write is visible the next cycle
    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_ready && hit.dir_hit) |=> dir_q == $past(bus_wdata));
    // R7: forwarded accesses never complete in the start cycle
    p_fwd_not_immediate_r7: assert property (@(posedge clk) disable iff (rst)
        fwd_start |-> !bus_ready);

endmodule

// File: tb/gpio_bidir_port_tb.sv
module gpio_bidir_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_ready;
    logic [7:0] pin_in = '0, pin_out, pin_oe;
    logic [7:0] xbus_dout = '0, xbus_din;
    logic       xbus_oe = 1'b0;
    logic       ext_req, ext_wr, ext_ack = 1'b0;
    logic [7:0] ext_addr, ext_wdata, ext_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_bidir_port dut_i (
        .clk(clk), .rst(rst), .mode(mode),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .xbus_dout(xbus_dout), .xbus_oe(xbus_oe), .xbus_din(xbus_din),
        .ext_req(ext_req), .ext_wr(ext_wr), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_data = '0, m_dir = '0;
    int         m_phase = 0;
    logic [7:0] m_hist[$] = '{8'h00, 8'h00};

    function automatic bit emul_acc();
        return bus_sel && mode[1] && bus_addr == 8'h05;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_data = '0; m_dir = '0; m_phase = 0;
            m_hist = '{8'h00, 8'h00};
        end else begin
            case (m_phase)
                0: if (emul_acc()) m_phase = 1;
                   else if (bus_sel && bus_wr) begin
                       if (bus_addr == 8'h05) m_data = bus_wdata;
                       if (bus_addr == 8'h06) m_dir  = bus_wdata;
                   end
                1: m_phase = 2;
                default: if (ext_ack) begin
                       if (bus_wr) m_data = bus_wdata;
                       m_phase = 0;
                   end
            endcase
            m_hist.push_front(pin_in);
            void'(m_hist.pop_back());
        end
    end

    // Compare against the model on every clock
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!rst) begin
                logic [7:0] e_oe, e_out, e_rd, sync;
                bit e_rdy, acc;
                string ptag, rtag;
                sync = m_hist[1];
                acc  = emul_acc();
                ptag = (mode == 2'b00) ? "R5" : "R6";
                e_oe  = (mode != 2'b00) ? {8{xbus_oe}} : m_dir;
                e_out = (mode != 2'b00) ? xbus_dout : m_data;
                chk({ptag, " pin_oe"}, pin_oe, e_oe);
                chk({ptag, " pin_out"}, pin_out, e_out);
                chk("R4 xbus_din", xbus_din, sync);
                chk("R7 ext_req", {7'd0, ext_req}, {7'd0, m_phase == 1});
                e_rdy = acc ? (m_phase == 2 && ext_ack) : bus_sel;
                chk(acc ? "R7 bus_ready" : "R10 bus_ready", {7'd0, bus_ready}, {7'd0, e_rdy});
                if (m_phase == 1) begin
                    chk("R8 ext_wr", {7'd0, ext_wr}, {7'd0, bus_wr});
                    chk("R7 ext_addr", ext_addr, 8'h05);
                    if (bus_wr) chk("R8 ext_wdata", ext_wdata, bus_wdata);
                end
                if (e_rdy && !bus_wr) begin
                    if (acc) begin
                        e_rd = ext_rdata;
                        rtag = (mode == 2'b11) ? "R11 rdata" : "R7 rdata";
                    end else if (bus_addr == 8'h05) begin
                        e_rd = (m_data & m_dir) | (sync & ~m_dir);
                        rtag = "R3 rdata";
                    end else if (bus_addr == 8'h06) begin
                        e_rd = m_dir; rtag = "R2 rdata";
                    end else begin
                        e_rd = 8'h00; rtag = "R9 rdata";
                    end
                    chk(rtag, bus_rdata, e_rd);
                end
            end
        end
    end

    task automatic lacc(input logic w, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #5 rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic eacc(input logic w, input logic [7:0] d, input int dly,
                        input logic [7:0] rsp, output logic [7:0] rd,
                        output logic rdy, output int reqs);
        reqs = 0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = 8'h05; bus_wdata = d;
        ext_rdata = rsp; ext_ack = 1'b0;
        #5 if (ext_req) reqs++;
        @(negedge clk);
        #5 if (ext_req) reqs++;
        for (int i = 0; i <= dly; i++) begin
            @(negedge clk);
            ext_ack = (i == dly);
            #5 if (ext_req) reqs++;
        end
        rd = bus_rdata; rdy = bus_ready;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ext_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic rdy;
        int reqs;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #5 chk("R1 pin_oe", pin_oe, 8'h00);
        lacc(1'b0, 8'h05, 8'h00, rd); chk("R1 data", rd, 8'h00);
        lacc(1'b0, 8'h06, 8'h00, rd); chk("R1 dir", rd, 8'h00);

        // R2: direction register
        lacc(1'b1, 8'h06, 8'hF0, rd);
        lacc(1'b0, 8'h06, 8'h00, rd); chk("R2 dir readback", rd, 8'hF0);
        lacc(1'b1, 8'h05, 8'hA5, rd);

        // R3: per-bit read source
        pin_in = 8'h3C;
        repeat (3) @(negedge clk);
        lacc(1'b0, 8'h05, 8'h00, rd); chk("R3 mixed read", rd, 8'hAC);

        // R4: two-edge input latency
        @(negedge clk); pin_in = 8'hC3;
        @(negedge clk); #5 chk("R4 one edge", xbus_din, 8'h3C);
        @(negedge clk); #5 chk("R4 two edges", xbus_din, 8'hC3);

        // R5: normal pin drive
        chk("R5 pin_oe", pin_oe, 8'hF0);
        chk("R5 pin_out", pin_out, 8'hA5);

        // R6: expanded mode pins follow external bus
        @(negedge clk); mode = 2'b01; xbus_dout = 8'h5A; xbus_oe = 1'b1;
        lacc(1'b1, 8'h05, 8'h11, rd);
        #5 chk("R6 pin_out", pin_out, 8'h5A);
        chk("R6 pin_oe", pin_oe, 8'hFF);
        @(negedge clk); xbus_oe = 1'b0;
        #5 chk("R6 oe off", pin_oe, 8'h00);

        // R7: forwarded read, slow acknowledge
        @(negedge clk); mode = 2'b10;
        eacc(1'b0, 8'h00, 3, 8'h77, rd, rdy, reqs);
        chk("R7 rdata", rd, 8'h77);
        chk("R7 ready", {7'd0, rdy}, 8'h01);
        chk("R7 one request", 8'(reqs), 8'h01);

        // R10: direction access stays local in emulation
        lacc(1'b1, 8'h06, 8'hFF, rd);

        // R8: forwarded write, immediate acknowledge
        eacc(1'b1, 8'h42, 0, 8'h00, rd, rdy, reqs);
        chk("R8 ready", {7'd0, rdy}, 8'h01);
        chk("R8 one request", 8'(reqs), 8'h01);
        @(negedge clk); mode = 2'b00;
        lacc(1'b0, 8'h05, 8'h00, rd); chk("R8 local copy", rd, 8'h42);

        // R9: unmapped offsets
        lacc(1'b1, 8'h07, 8'h00, rd);
        lacc(1'b0, 8'h07, 8'h00, rd); chk("R9 unmapped read", rd, 8'h00);
        lacc(1'b1, 8'h04, 8'h00, rd);
        lacc(1'b0, 8'h05, 8'h00, rd); chk("R9 data kept", rd, 8'h42);
        lacc(1'b0, 8'h06, 8'h00, rd); chk("R9 dir kept", rd, 8'hFF);

        // R11: mode 11 forwards like emulation
        @(negedge clk); mode = 2'b11;
        eacc(1'b0, 8'h00, 1, 8'h99, rd, rdy, reqs);
        chk("R11 rdata", rd, 8'h99);
        chk("R11 one request", 8'(reqs), 8'h01);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule